// File: doc/BRIEF.md
# Regulator Setpoint Mode Sequencer

This block is the digital front end of a core-voltage regulator. It decides which output voltage the regulator should aim for and produces a reference that moves gradually toward that aim. It accepts a 6-bit voltage identification code, a deep-sleep request that is active low, a deeper-sleep request that is active high, an enable and a power-good input from other supply rails. It also takes three setpoints as register-style inputs: boot, deep-sleep and deeper-sleep. All voltages are unsigned millivolt codes.

After enable rises, the reference climbs to the boot setpoint and stays there until the external good signal arrives. From then on the target follows the identification code or one of the two sleep setpoints. Every change of target is slewed. The reference moves by 1 mV once per programmed number of clock cycles and stops exactly on the target. A transition flag is high whenever the reference and the target differ, so a downstream monitor can mask its window checks while the flag is high. Dropping enable clears the reference and sends the sequencer back to idle.

Top module: `setpoint_sequencer`

## Requirements
- R1: In the running phase, with no sleep mode requested, the target is 1708 − 16·code mV. Code 0 gives 1708 mV and code 63 gives 700 mV.
- R2: In the running phase, a low level on `deepSleepN` (with `deeperSleep` low) makes the target equal `deepMv`.
- R3: In the running phase, a high level on `deeperSleep` makes the target equal `deeperMv`, whatever the level of `deepSleepN`.
- R4: After enable rises from idle, the target is `bootMv` from the next cycle on. It stays `bootMv` while `extGood` is low, whatever the code and sleep inputs do.
- R5: The sequencer enters the running phase in the cycle after `extGood` is high while the reference equals `bootMv`. Once it is running, a later low level on `extGood` has no effect.
- R6: While the reference differs from the target, it moves 1 mV toward the target once every `slewDiv` cycles. A `slewDiv` of 0 behaves as 1. No step ever exceeds 1 mV.
- R7: The reference never passes the target. Once it reaches the target it holds there.
- R8: `slewing` is high exactly when `rampMv` differs from `targetMv`.
- R9: When `enable` is low, the next cycle shows `rampMv` = 0, `targetMv` = 0 and `slewing` = 0. When enable rises again, the sequence restarts at the boot setpoint.
- R10: Right after reset, `rampMv`, `targetMv` and `slewing` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Regulator enable; low returns the block to idle |
| vidCode | input | 6 | Voltage identification code |
| deepSleepN | input | 1 | Deep-sleep request, active low |
| deeperSleep | input | 1 | Deeper-sleep request, active high |
| extGood | input | 1 | Power-good from the other rails; releases the boot hold |
| bootMv | input | 11 | Boot setpoint in mV |
| deepMv | input | 11 | Deep-sleep setpoint in mV |
| deeperMv | input | 11 | Deeper-sleep setpoint in mV |
| slewDiv | input | 8 | Clock cycles per 1 mV step of the reference |
| targetMv | output | 11 | Current target in mV |
| rampMv | output | 11 | Slewed reference in mV |
| slewing | output | 1 | High while the reference differs from the target |

## Verification
The hardest situation to reach from the ports is the boot hold being released at the exact moment the reference settles. At that point `extGood` has to be sampled against a reference that has just arrived at the boot value, and the sleep and code inputs must already be pointing somewhere else. The directed part of the stimulus climbs all the way to boot with the mode inputs toggled to other values. It then raises `extGood` and checks the first running target. The random part changes the setpoints, rates and enable while the ramps are still in flight, including enable drops mid-ramp, so the boot hold is reached again from many different states. A cycle model in the bench follows every one of these paths.

// File: rtl/spseq_pkg.sv
package spseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BOOT = 2'd1,
    ST_RUN  = 2'd2
  } seqState_t;

  typedef enum logic [2:0] {
    SEL_ZERO   = 3'd0,
    SEL_BOOT   = 3'd1,
    SEL_VID    = 3'd2,
    SEL_DEEP   = 3'd3,
    SEL_DEEPER = 3'd4
  } tgtSel_t;

  typedef struct packed {
    logic    clearRamp;
    logic    stepEn;
    tgtSel_t tgtSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/spseq_vid_decode.sv
module spseq_vid_decode #(
  parameter int VID_W   = 6,
  parameter int MV_W    = 11,
  parameter int TOP_MV  = 1708,
  parameter int STEP_MV = 16
) (
  input  logic [VID_W-1:0] vidCode,
  output logic [MV_W-1:0]  vidMv
);

  localparam int LOW_MV = TOP_MV - STEP_MV * ((1 << VID_W) - 1);
  localparam logic [MV_W-1:0] TOP_CODE  = MV_W'(TOP_MV);
  localparam logic [MV_W-1:0] STEP_CODE = MV_W'(STEP_MV);

  initial begin
    if (LOW_MV < 0) $error("code range reaches below zero millivolts");
    if (TOP_MV >= (1 << MV_W)) $error("top setpoint does not fit the millivolt width");
  end

  // Larger codes mean lower voltages
  assign vidMv = TOP_CODE - (STEP_CODE * MV_W'(vidCode));

endmodule

// File: rtl/spseq_ctrl.sv
module spseq_ctrl
  import spseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        deepSleepN,
  input  logic        deeperSleep,
  input  logic        extGood,
  input  logic        atTarget,
  output ctrlStrobe_t strobe
);

  seqState_t curState, nxtState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) curState <= ST_IDLE;
    else        curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    if (!enable) begin
      nxtState = ST_IDLE;
    end else begin
      case (curState)
        ST_IDLE: nxtState = ST_BOOT;
        // In boot the target is the boot setpoint, so atTarget means boot reached
        ST_BOOT: if (extGood && atTarget) nxtState = ST_RUN;
        ST_RUN:  nxtState = ST_RUN;
        default: nxtState = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clearRamp = !enable;
    strobe.stepEn    = enable && (curState != ST_IDLE);
    case (curState)
      ST_BOOT: strobe.tgtSel = SEL_BOOT;
      ST_RUN: begin
        if (deeperSleep)      strobe.tgtSel = SEL_DEEPER;
        else if (!deepSleepN) strobe.tgtSel = SEL_DEEP;
        else                  strobe.tgtSel = SEL_VID;
      end
      default: strobe.tgtSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/spseq_datapath.sv
module spseq_datapath
  import spseq_pkg::*;
#(
  parameter int MV_W  = 11,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [MV_W-1:0]   bootMv,
  input  logic [MV_W-1:0]   vidMv,
  input  logic [MV_W-1:0]   deepMv,
  input  logic [MV_W-1:0]   deeperMv,
  input  logic [DIV_W-1:0]  slewDiv,
  output logic [MV_W-1:0]   targetMv,
  output logic [MV_W-1:0]   rampMv,
  output logic              atTarget,
  output logic              slewing
);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic             rampBelow;

  always_comb begin
    case (strobe.tgtSel)
      SEL_BOOT:   targetMv = bootMv;
      SEL_VID:    targetMv = vidMv;
      SEL_DEEP:   targetMv = deepMv;
      SEL_DEEPER: targetMv = deeperMv;
      default:    targetMv = '0;
    endcase
  end

  assign atTarget  = (rampMv == targetMv);
  assign rampBelow = (rampMv < targetMv);
  assign slewing   = !atTarget;
  // A zero rate setting is taken as one cycle per step
  assign divLimit  = (slewDiv == '0) ? '0 : slewDiv - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rampMv <= '0;
      divCnt <= '0;
    end else if (strobe.clearRamp) begin
      rampMv <= '0;
      divCnt <= '0;
    end else if (!strobe.stepEn || atTarget) begin
      divCnt <= '0;
    end else if (divCnt >= divLimit) begin
      divCnt <= '0;
      if (rampBelow) rampMv <= rampMv + 1'b1;
      else           rampMv <= rampMv - 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

endmodule

// File: rtl/setpoint_sequencer.sv
module setpoint_sequencer
  import spseq_pkg::*;
#(
  parameter int VID_W   = 6,
  parameter int MV_W    = 11,
  parameter int DIV_W   = 8,
  parameter int TOP_MV  = 1708,
  parameter int STEP_MV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [VID_W-1:0]  vidCode,
  input  logic              deepSleepN,
  input  logic              deeperSleep,
  input  logic              extGood,
  input  logic [MV_W-1:0]   bootMv,
  input  logic [MV_W-1:0]   deepMv,
  input  logic [MV_W-1:0]   deeperMv,
  input  logic [DIV_W-1:0]  slewDiv,
  output logic [MV_W-1:0]   targetMv,
  output logic [MV_W-1:0]   rampMv,
  output logic              slewing
);

  ctrlStrobe_t     strobe;
  logic [MV_W-1:0] vidMv;
  logic            atTarget;

  spseq_vid_decode #(
    .VID_W(VID_W), .MV_W(MV_W), .TOP_MV(TOP_MV), .STEP_MV(STEP_MV)
  ) decode_i (
    .vidCode (vidCode),
    .vidMv   (vidMv)
  );

  spseq_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .deepSleepN  (deepSleepN),
    .deeperSleep (deeperSleep),
    .extGood     (extGood),
    .atTarget    (atTarget),
    .strobe      (strobe)
  );

  spseq_datapath #(
    .MV_W(MV_W), .DIV_W(DIV_W)
  ) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .bootMv   (bootMv),
    .vidMv    (vidMv),
    .deepMv   (deepMv),
    .deeperMv (deeperMv),
    .slewDiv  (slewDiv),
    .targetMv (targetMv),
    .rampMv   (rampMv),
    .atTarget (atTarget),
    .slewing  (slewing)
  );

endmodule

// File: rtl/setpoint_sequencer_chk.sv
module setpoint_sequencer_chk #(
  parameter int MV_W = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic [MV_W-1:0] targetMv,
  input logic [MV_W-1:0] rampMv,
  input logic            slewing
);

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (rampMv == '0 && targetMv == '0 && !slewing)); // R9

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> (rampMv == $past(rampMv) ||
                       rampMv == $past(rampMv) + 1'b1 ||
                       rampMv == $past(rampMv) - 1'b1)); // R6

  AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && $past(rampMv) <= $past(targetMv)) |-> rampMv <= $past(targetMv)); // R7

  AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && $past(rampMv) >= $past(targetMv)) |-> rampMv >= $past(targetMv)); // R7

  AST_SETTLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$past(slewing)) |-> rampMv == $past(rampMv)); // R8

endmodule

bind setpoint_sequencer setpoint_sequencer_chk #(.MV_W(MV_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .targetMv (targetMv),
  .rampMv   (rampMv),
  .slewing  (slewing)
);

// File: tb/setpoint_sequencer_tb_top.sv
module setpoint_sequencer_tb_top;

  localparam int VID_W = 6;
  localparam int MV_W  = 11;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic [VID_W-1:0] vidCode = '0;
  logic             deepSleepN = 1'b1;
  logic             deeperSleep = 1'b0;
  logic             extGood = 1'b0;
  logic [MV_W-1:0]  bootMv = 11'd750;
  logic [MV_W-1:0]  deepMv = 11'd900;
  logic [MV_W-1:0]  deeperMv = 11'd760;
  logic [DIV_W-1:0] slewDiv = '0;
  logic [MV_W-1:0]  targetMv;
  logic [MV_W-1:0]  rampMv;
  logic             slewing;

  int errCount = 0;
  int chkCount = 0;
  bit doneFlag = 0;

  // Model state: 0 idle, 1 boot, 2 running
  int mState = 0;
  int mRamp  = 0;
  int mCnt   = 0;

  always #2 clk = ~clk;

  setpoint_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .vidCode(vidCode),
    .deepSleepN(deepSleepN), .deeperSleep(deeperSleep), .extGood(extGood),
    .bootMv(bootMv), .deepMv(deepMv), .deeperMv(deeperMv), .slewDiv(slewDiv),
    .targetMv(targetMv), .rampMv(rampMv), .slewing(slewing)
  );

  function automatic int vidToMv(int code);
    return 1708 - 16 * code;
  endfunction

  function automatic int modelTarget(int st);
    if (st == 1) return int'(bootMv);
    if (st == 2) begin
      if (deeperSleep)  return int'(deeperMv);
      if (!deepSleepN)  return int'(deepMv);
      return vidToMv(int'(vidCode));
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mState = 0; mRamp = 0; mCnt = 0;
    end else begin
      int tgt;
      int lim;
      tgt = modelTarget(mState);
      lim = (slewDiv == 0) ? 0 : int'(slewDiv) - 1;
      if (!enable) begin
        mState = 0; mRamp = 0; mCnt = 0;
      end else begin
        int nst;
        nst = mState;
        if (mState == 0) nst = 1;
        else if (mState == 1 && extGood && mRamp == tgt) nst = 2;
        if (mState == 0 || mRamp == tgt) mCnt = 0;
        else if (mCnt >= lim) begin
          mCnt = 0;
          mRamp = (mRamp < tgt) ? mRamp + 1 : mRamp - 1;
        end else mCnt = mCnt + 1;
        mState = nst;
      end
    end
  end

  task automatic checkEq(string tag, string what, int act, int exp);
    chkCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cycleCheck();
    int expT;
    string tTag;
    expT = modelTarget(mState);
    if (mState == 1) tTag = "R4";
    else if (mState == 2) tTag = deeperSleep ? "R3" : (!deepSleepN ? "R2" : "R1");
    else tTag = "R9";
    checkEq(tTag, "targetMv", int'(targetMv), expT);
    checkEq("R6", "rampMv", int'(rampMv), mRamp);
    checkEq("R8", "slewing", int'(slewing), int'(mRamp != expT));
  endtask

  task automatic runCycles(int n);
    repeat (n) begin
      @(negedge clk);
      cycleCheck();
    end
  endtask

  task automatic measureSettle(string tag, int exp);
    int k = 0;
    do begin
      @(negedge clk);
      cycleCheck();
      k++;
    end while (slewing && k < 5000);
    checkEq(tag, "settle cycles", k, exp);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    errCount++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    repeat (3) @(negedge clk);
    // R10 reset state
    checkEq("R10", "rampMv", int'(rampMv), 0);
    checkEq("R10", "targetMv", int'(targetMv), 0);
    checkEq("R10", "slewing", int'(slewing), 0);
    rst_n = 1'b1;
    runCycles(2);

    // R4 climb to boot and hold without the good signal
    enable = 1'b1;
    runCycles(2);
    checkEq("R4", "boot target", int'(targetMv), 750);
    runCycles(800);
    checkEq("R4", "ramp at boot", int'(rampMv), 750);
    deeperSleep = 1'b1; deepSleepN = 1'b0; vidCode = 6'd63;
    runCycles(20);
    checkEq("R4", "held target", int'(targetMv), 750);
    checkEq("R4", "held ramp", int'(rampMv), 750);
    deeperSleep = 1'b0; deepSleepN = 1'b1; vidCode = '0;

    // R5 release, then R1 top code
    extGood = 1'b1;
    runCycles(2);
    checkEq("R1", "code 0 target", int'(targetMv), 1708);
    runCycles(1000);
    checkEq("R7", "settled ramp", int'(rampMv), 1708);
    extGood = 1'b0;
    runCycles(5);
    checkEq("R5", "good drop ignored", int'(targetMv), 1708);

    // R1 bottom code
    vidCode = 6'd63;
    #1;
    checkEq("R1", "code 63 target", int'(targetMv), 700);
    runCycles(1100);
    checkEq("R7", "settled low", int'(rampMv), 700);

    // R6 rate: 16 mV at 5 cycles each, then at rate 0
    vidCode = 6'd62; slewDiv = 8'd5;
    measureSettle("R6", 80);
    vidCode = 6'd63; slewDiv = 8'd0;
    measureSettle("R6", 16);

    // R2 and R3 priority
    deepSleepN = 1'b0;
    #1;
    checkEq("R2", "deep target", int'(targetMv), 900);
    deeperSleep = 1'b1;
    #1;
    checkEq("R3", "deeper priority", int'(targetMv), 760);
    runCycles(300);

    // R9 disable and restart
    enable = 1'b0;
    runCycles(1);
    checkEq("R9", "ramp cleared", int'(rampMv), 0);
    checkEq("R9", "target cleared", int'(targetMv), 0);
    checkEq("R9", "flag cleared", int'(slewing), 0);
    enable = 1'b1;
    runCycles(2);
    checkEq("R9", "restart at boot", int'(targetMv), 750);

    // Constrained random phase
    for (int i = 0; i < 150; i++) begin
      int r = int'($urandom % 100);
      if (r < 6) enable = 1'b0;
      else enable = 1'b1;
      vidCode = VID_W'($urandom);
      deepSleepN = ($urandom % 3) != 0;
      deeperSleep = ($urandom % 4) == 0;
      extGood = ($urandom % 3) != 0;
      slewDiv = DIV_W'($urandom % 3);
      if (r > 80) begin
        bootMv   = MV_W'(700 + $urandom % 1009);
        deepMv   = MV_W'(700 + $urandom % 1009);
        deeperMv = MV_W'(700 + $urandom % 1009);
      end
      runCycles(50 + int'($urandom % 150));
    end
    finishRun();
  end

endmodule